// File: doc/BRIEF.md
# Self-Polling Bit-Check Controller

This block paces a radio receiver through a low-power polling loop. The receiver is held unpowered for a programmable sleep time and then powered for a fixed start-up time. After start-up the block times the edges of the demodulated data stream. A run of well-timed half-bit intervals moves the block into a continuous receive mode. A mistimed edge, or a stream that goes quiet, sends it back to sleep. All timing is counted in ticks of a base clock enable.

A mode pin held low bypasses polling and forces receive mode. Receive mode is left only through an OFF command, and only while the mode pin is high. The outputs tell the analog side when to power the receiver, when the data is being judged or passed on, and when the block is in receive mode.

Top module: `poll_bitcheck_ctrl`

## Requirements
- R1: After reset the block is in the sleep phase with `power_en`, `active` and `recv_mode` all low.
- R2: The sleep phase lasts exactly `sleep_cnt` × 1024 × F ticks, where F is 8 when `sleep_ext` is 1 and 1 when it is 0. A product of zero gives one tick. `power_en` rises at the end of the sleep phase.
- R3: The start-up phase lasts exactly 16 ticks. During start-up `power_en` is high and `active` is low, and data edges have no effect.
- R4: During the check phase `active` is high and `recv_mode` is low. The first data edge in the check phase only starts a measurement. Each later edge closes an interval, measured in ticks since the previous edge.
- R5: An interval shorter than `lim_min` ticks ends the check. The block returns to sleep and `power_en` falls one cycle after the edge.
- R6: The check also ends, returning the block to sleep, when `lim_max` ticks pass with no edge. This is counted from check entry or from the last edge. An interval of exactly `lim_max` ticks therefore fails.
- R7: After `good_need` consecutive intervals in the range [`lim_min`, `lim_max`−1], the block enters receive mode one cycle after the closing edge. A `good_need` of 0 acts as 1.
- R8: In receive mode `power_en`, `active` and `recv_mode` are all high, and they stay high whatever the data does.
- R9: `mode_n` low puts the block in receive mode one cycle later, from any phase.
- R10: `off_cmd` high in receive mode returns the block to sleep when `mode_n` is high. While `mode_n` is low, `off_cmd` is ignored.
- R11: The limit inputs are 6 bits wide, so any pair with 1 ≤ `lim_min` < `lim_max` ≤ 63 is accepted, including 14 and 24.
- R12: With `tick` low, the sleep, start-up and interval counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Base clock enable, one pulse per timing unit |
| demod_in | input | 1 | Demodulated data stream |
| sleep_cnt | input | 5 | Sleep length in units of 1024 ticks |
| sleep_ext | input | 1 | 1 multiplies the sleep length by 8 |
| lim_min | input | 6 | Shortest valid interval in ticks |
| lim_max | input | 6 | Interval length in ticks that counts as too long |
| good_need | input | 4 | Valid intervals needed to pass the check |
| mode_n | input | 1 | Low forces receive mode |
| off_cmd | input | 1 | Leaves receive mode when mode_n is high |
| power_en | output | 1 | Receiver power enable |
| active | output | 1 | High during the check phase and receive mode |
| recv_mode | output | 1 | High in receive mode |

## Verification
All outputs are registered phase decodes, so each result appears in the cycle after the clock edge that sees its cause. A sleep of T ticks raises `power_en` on the T-th edge after reset, and `active` follows 16 edges after that. An edge driven before edge P is judged at P, and the verdict shows after P. The bench drives inputs and samples outputs on falling edges. It checks each timed boundary one cycle before and one cycle at the expected edge, and it places each data toggle so that the intended interval is exactly the one measured.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    PH_SLEEP = 2'd0,
    PH_START = 2'd1,
    PH_CHECK = 2'd2,
    PH_RECV  = 2'd3
  } phase_t;

  // Number of ticks spent asleep for a given setting.
  function automatic int unsigned sleep_ticks(input int unsigned val,
                                              input bit          ext,
                                              input int unsigned unit,
                                              input int unsigned factor);
    int unsigned mult;
    mult = ext ? factor : 1;
    return val * unit * mult;
  endfunction

  // An interval is acceptable when lo <= meas < hi.
  function automatic bit interval_ok(input int unsigned meas,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (meas >= lo) && (meas < hi);
  endfunction

  // A required count of zero behaves as one.
  function automatic int unsigned need_eff(input int unsigned need);
    return (need == 0) ? 1 : need;
  endfunction

endpackage

// File: rtl/pbc_phase_timer.sv
module pbc_phase_timer #(
  parameter int TGT_W       = 18,
  parameter int START_TICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             in_sleep,
  input  logic             in_start,
  input  logic [TGT_W-1:0] target,
  output logic             sleep_done,
  output logic             start_done
);
  localparam int SW = $clog2(START_TICKS + 1);
  localparam int CW = (TGT_W > SW) ? TGT_W : SW;

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;
  logic          running;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign running = in_sleep | in_start;

  assign sleep_done = in_sleep & tick & (cnt_inc >= (CW+1)'(target));
  assign start_done = in_start & tick & (cnt_inc >= (CW+1)'(START_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (tick && running) cnt_q <= cnt_inc[CW-1:0];
  end
endmodule

// File: rtl/pbc_bitcheck.sv
module pbc_bitcheck
  import pbc_pkg::*;
#(
  parameter int LIM_W = 6,
  parameter int NB_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             data_in,
  input  logic             en,
  input  logic             clr,
  input  logic [LIM_W-1:0] lim_min,
  input  logic [LIM_W-1:0] lim_max,
  input  logic [NB_W-1:0]  need,
  output logic             pass,
  output logic             fail
);
  localparam int CNT_W = LIM_W + 1;

  logic             d_q;
  logic             edge_now;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] meas;
  logic [NB_W:0]    good_q;
  logic [NB_W:0]    good_inc;
  logic             judge;
  logic             ok;
  logic             timeout;

  assign edge_now = data_in ^ d_q;
  assign meas     = cnt_q + CNT_W'(tick);
  assign judge    = en & edge_now & armed_q;
  assign ok       = interval_ok(32'(meas), 32'(lim_min), 32'(lim_max));
  assign good_inc = good_q + 1'b1;
  assign timeout  = en & ~edge_now & tick & ((cnt_q + 1'b1) >= CNT_W'(lim_max));

  assign pass = judge & ok & (32'(good_inc) >= need_eff(32'(need)));
  assign fail = (judge & ~ok) | timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      good_q  <= '0;
      armed_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      good_q  <= '0;
      armed_q <= 1'b0;
    end else if (en) begin
      if (edge_now) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (judge && ok) good_q <= good_inc;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbc_phase_fsm.sv
module pbc_phase_fsm
  import pbc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   force_rx,
  input  logic   off_cmd,
  input  logic   sleep_done,
  input  logic   start_done,
  input  logic   chk_pass,
  input  logic   chk_fail,
  output phase_t phase,
  output logic   phase_chg
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_SLEEP: if (force_rx) nxt = PH_RECV;
                else if (sleep_done) nxt = PH_START;
      PH_START: if (force_rx) nxt = PH_RECV;
                else if (start_done) nxt = PH_CHECK;
      PH_CHECK: if (force_rx || chk_pass) nxt = PH_RECV;
                else if (chk_fail) nxt = PH_SLEEP;
      PH_RECV:  if (off_cmd && !force_rx) nxt = PH_SLEEP;
      default:  nxt = PH_SLEEP;
    endcase
  end

  assign phase_chg = (nxt != phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_SLEEP;
    else        phase <= nxt;
  end
endmodule

// File: rtl/poll_bitcheck_ctrl.sv
module poll_bitcheck_ctrl
  import pbc_pkg::*;
#(
  parameter int SLEEP_W     = 5,
  parameter int SLEEP_UNIT  = 1024,
  parameter int EXT_FACTOR  = 8,
  parameter int START_TICKS = 16,
  parameter int LIM_W       = 6,
  parameter int NB_W        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               demod_in,
  input  logic [SLEEP_W-1:0] sleep_cnt,
  input  logic               sleep_ext,
  input  logic [LIM_W-1:0]   lim_min,
  input  logic [LIM_W-1:0]   lim_max,
  input  logic [NB_W-1:0]    good_need,
  input  logic               mode_n,
  input  logic               off_cmd,
  output logic               power_en,
  output logic               active,
  output logic               recv_mode
);
  localparam int MAX_SLEEP = ((1 << SLEEP_W) - 1) * SLEEP_UNIT * EXT_FACTOR;
  localparam int TGT_W     = $clog2(MAX_SLEEP + 1);

  phase_t           phase;
  logic             phase_chg;
  logic             sleep_done_w;
  logic             start_done_w;
  logic             chk_pass_w;
  logic             chk_fail_w;
  logic [TGT_W-1:0] sleep_tgt;

  assign sleep_tgt = TGT_W'(sleep_ticks(32'(sleep_cnt), sleep_ext,
                                        SLEEP_UNIT, EXT_FACTOR));

  pbc_phase_timer #(
    .TGT_W      (TGT_W),
    .START_TICKS(START_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clr       (phase_chg),
    .in_sleep  (phase == PH_SLEEP),
    .in_start  (phase == PH_START),
    .target    (sleep_tgt),
    .sleep_done(sleep_done_w),
    .start_done(start_done_w)
  );

  pbc_bitcheck #(
    .LIM_W(LIM_W),
    .NB_W (NB_W)
  ) u_check (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .data_in(demod_in),
    .en     (phase == PH_CHECK),
    .clr    (phase_chg),
    .lim_min(lim_min),
    .lim_max(lim_max),
    .need   (good_need),
    .pass   (chk_pass_w),
    .fail   (chk_fail_w)
  );

  pbc_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_rx  (~mode_n),
    .off_cmd   (off_cmd),
    .sleep_done(sleep_done_w),
    .start_done(start_done_w),
    .chk_pass  (chk_pass_w),
    .chk_fail  (chk_fail_w),
    .phase     (phase),
    .phase_chg (phase_chg)
  );

  assign power_en  = (phase != PH_SLEEP);
  assign active    = (phase == PH_CHECK) || (phase == PH_RECV);
  assign recv_mode = (phase == PH_RECV);
endmodule

// File: rtl/pbc_checker.sv
module pbc_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic mode_n,
  input logic off_cmd,
  input logic power_en,
  input logic active,
  input logic recv_mode,
  input logic chk_pass,
  input logic chk_fail
);
  // R3: power comes up into start-up, never straight into the check
  assert_startup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(power_en) && !recv_mode) |-> !active);

  // R4: no verdict is produced outside the check phase
  assert_no_verdict_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || recv_mode) |-> (!chk_pass && !chk_fail));

  // R5 and R6: a failed check drops power on the next cycle
  assert_fail_sleeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fail && !chk_pass && mode_n) |=> !power_en);

  // R7: a passed check enters receive mode
  assert_pass_recv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pass |=> recv_mode);

  // R8: receive mode keeps every output high
  assert_recv_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recv_mode |-> (power_en && active));

  // R9: mode pin low forces receive mode
  assert_force_recv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_n |=> recv_mode);

  // R10: OFF with the mode pin high leaves receive mode
  assert_off_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (recv_mode && off_cmd && mode_n) |=> !power_en);

  // R12: sleep cannot end without a tick
  assert_tick_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && mode_n && !power_en) |=> !power_en);
endmodule

bind poll_bitcheck_ctrl pbc_checker u_pbc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .mode_n   (mode_n),
  .off_cmd  (off_cmd),
  .power_en (power_en),
  .active   (active),
  .recv_mode(recv_mode),
  .chk_pass (chk_pass_w),
  .chk_fail (chk_fail_w)
);

// File: tb/poll_bitcheck_ctrl_test.sv
`timescale 1ns/1ps
module poll_bitcheck_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       demod_in = 1'b0;
  logic [4:0] sleep_cnt = 5'd1;
  logic       sleep_ext = 1'b0;
  logic [5:0] lim_min = 6'd14;
  logic [5:0] lim_max = 6'd24;
  logic [3:0] good_need = 4'd4;
  logic       mode_n = 1'b1;
  logic       off_cmd = 1'b0;
  logic       power_en, active, recv_mode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  poll_bitcheck_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .demod_in(demod_in),
    .sleep_cnt(sleep_cnt), .sleep_ext(sleep_ext),
    .lim_min(lim_min), .lim_max(lim_max), .good_need(good_need),
    .mode_n(mode_n), .off_cmd(off_cmd),
    .power_en(power_en), .active(active), .recv_mode(recv_mode)
  );

  // fields: lim_min[22:17] lim_max[16:11] need[10:7] interval[6:1] pass[0]
  localparam logic [22:0] VECS [0:9] = '{
    {6'd14, 6'd24, 4'd4, 6'd14, 1'b1},
    {6'd14, 6'd24, 4'd4, 6'd23, 1'b1},
    {6'd14, 6'd24, 4'd4, 6'd13, 1'b0},
    {6'd14, 6'd24, 4'd4, 6'd24, 1'b0},
    {6'd14, 6'd24, 4'd4, 6'd30, 1'b0},
    {6'd14, 6'd24, 4'd1, 6'd18, 1'b1},
    {6'd5,  6'd9,  4'd3, 6'd7,  1'b1},
    {6'd5,  6'd9,  4'd3, 6'd4,  1'b0},
    {6'd3,  6'd63, 4'd2, 6'd62, 1'b1},
    {6'd10, 6'd12, 4'd0, 6'd11, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input logic [22:0] v);
    int ivl;
    int n;
    lim_min   = v[22:17];
    lim_max   = v[16:11];
    good_need = v[10:7];
    ivl       = int'(v[6:1]);
    n         = (v[10:7] == 0) ? 1 : int'(v[10:7]);
    sleep_cnt = 5'd1;
    sleep_ext = 1'b0;
    tick      = 1'b1;
    do_reset();
    step(1024 + 16);
    check("R4 check phase active", int'({active, recv_mode}), 2);
    demod_in = ~demod_in;
    step(1);
    for (int i = 0; i < n; i++) begin
      step(ivl - 1);
      demod_in = ~demod_in;
      step(1);
    end
    if (v[0])
      check("R7/R11 vector pass recv_mode", int'(recv_mode), 1);
    else
      check("R5/R6 vector fail power_en", int'({power_en, active}), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(2);
    check("R1 reset outputs", int'({power_en, active, recv_mode}), 0);
    rst_n = 1'b1;

    // Table of bit-check scenarios (R5 R6 R7 R11)
    for (int v = 0; v < 10; v++) run_vec(VECS[v]);

    // R8: receive mode holds with a silent line
    run_vec({6'd14, 6'd24, 4'd2, 6'd20, 1'b1});
    step(200);
    check("R8 recv holds", int'({power_en, active, recv_mode}), 7);

    // R2: sleep of 2 units, then R3 start-up with edges ignored, then R6 timeout
    sleep_cnt = 5'd2; sleep_ext = 1'b0; lim_min = 6'd14; lim_max = 6'd24;
    do_reset();
    step(2047);
    check("R2 sleep not yet over", int'(power_en), 0);
    step(1);
    check("R2 sleep ends at 2048", int'(power_en), 1);
    for (int i = 0; i < 15; i++) begin
      demod_in = ~demod_in;
      step(1);
    end
    check("R3 start-up still inactive", int'({power_en, active}), 2);
    step(1);
    check("R3 start-up ends at 16", int'({power_en, active}), 3);
    step(23);
    check("R6 no timeout before lim_max", int'(active), 1);
    step(1);
    check("R6 timeout at lim_max", int'(power_en), 0);

    // R2: extension factor
    sleep_cnt = 5'd1; sleep_ext = 1'b1;
    do_reset();
    step(8191);
    check("R2 extended sleep not over", int'(power_en), 0);
    step(1);
    check("R2 extended sleep ends at 8192", int'(power_en), 1);

    // R2: zero sleep value gives one tick
    sleep_cnt = 5'd0; sleep_ext = 1'b0;
    do_reset();
    step(1);
    check("R2 zero sleep one tick", int'(power_en), 1);

    // R12: tick low freezes the sleep counter
    sleep_cnt = 5'd1; sleep_ext = 1'b0; tick = 1'b0;
    do_reset();
    step(2000);
    check("R12 frozen sleep", int'(power_en), 0);
    tick = 1'b1;
    step(1023);
    check("R12 resumed count not over", int'(power_en), 0);
    step(1);
    check("R12 resumed count ends", int'(power_en), 1);

    // R9 and R10: forced receive and OFF command
    sleep_cnt = 5'd2;
    do_reset();
    step(10);
    off_cmd = 1'b1;
    step(1);
    check("R10 off ignored outside recv", int'(power_en), 0);
    off_cmd = 1'b0;
    mode_n = 1'b0;
    step(1);
    check("R9 forced recv", int'({power_en, active, recv_mode}), 7);
    off_cmd = 1'b1;
    step(1);
    check("R10 off ignored with pin low", int'(recv_mode), 1);
    mode_n = 1'b1;
    step(1);
    check("R10 off exits recv", int'({power_en, recv_mode}), 0);
    off_cmd = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule